// File: doc/BRIEF.md
# Data Access Alignment Fault Unit

This block sits between the address generators of a processor core and the data memory interface. Every cycle it examines the accesses that the address-generator ports present, each with a byte address, an access size and a read/write flag. It decides from the size and the low address bits whether each access is naturally aligned. Aligned accesses pass straight through to the memory strobes. When any port presents a misaligned access, every memory operation of that cycle is withheld, so the whole instruction is cancelled and can be re-executed exactly.

In the same cycle as detection, the unit loads three capture registers. A status register receives a fixed alignment cause code. A fault address register receives the exact unaligned byte address. A return address register receives the program counter of the offending instruction. One cycle later it raises a synchronous exception request to the sequencer. Software may preset the fault address register through a dedicated write port, and that value is kept until the next fault.

Top module: `dalign_fault_unit`

## Requirements
- R1: A halfword access (size code 2'b01) is misaligned when address bit 0 is 1.
- R2: A word access (size code 2'b10) is misaligned when address bits [1:0] are anything other than 2'b00, so offsets 1, 2 and 3 all fault. The spare size code 2'b11 is checked like a word.
- R3: A byte access (size code 2'b00) never faults, at any address.
- R4: Each port is checked on its own, whether or not the other port is active in the same cycle, and loads (wr=0) are checked exactly like stores (wr=1).
- R5: In a cycle with no fault, mem_req equals acc_vld, mem_we equals acc_vld AND acc_wr, and load_en equals acc_vld AND NOT acc_wr, bit by bit. In a cycle where any valid port faults, all three are zero on every port in that same cycle.
- R6: exc_req is high in the cycle after a faulting cycle and low in the cycle after a non-faulting cycle. Each faulting cycle therefore gives one single-cycle pulse.
- R7: After a fault, cause_q reads 8'h24. Non-faulting cycles leave it unchanged.
- R8: After a fault, fault_addr_q holds the unmodified byte address of the faulting access. When both ports fault in the same cycle, port 0's address is recorded.
- R9: After a fault, ret_pc_q holds the instr_pc value presented in the faulting cycle.
- R10: With sw_fa_we high and no fault, fault_addr_q takes sw_fa_data at the next edge and holds it until the next fault or software write. A fault in the same cycle as a software write takes precedence.
- R11: While rst_n is low at a clock edge, exc_req, cause_q, fault_addr_q and ret_pc_q are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_vld | input | NP (2) | Per-port access valid |
| acc_addr | input | NP*AW (64) | Per-port byte address, port p at bits [p*AW +: AW] |
| acc_size | input | NP*2 (4) | Per-port size code: 00 byte, 01 half, 10 word, 11 word |
| acc_wr | input | NP (2) | Per-port direction, 1 = store, 0 = load |
| instr_pc | input | PCW (32) | PC of the instruction issuing this cycle's accesses |
| sw_fa_we | input | 1 | Software write enable for the fault address register |
| sw_fa_data | input | AW (32) | Software write data for the fault address register |
| mem_req | output | NP (2) | Per-port memory request after suppression |
| mem_we | output | NP (2) | Per-port memory write strobe after suppression |
| load_en | output | NP (2) | Per-port load destination update enable after suppression |
| exc_req | output | 1 | Exception request pulse to the sequencer |
| cause_q | output | CW (8) | Exception cause status |
| fault_addr_q | output | AW (32) | Captured faulting data address |
| ret_pc_q | output | PCW (32) | Captured exception return address |

## Verification
The bench builds the unit with its defaults: two ports, 32-bit addresses and PCs, and the 8-bit cause code 8'h24. Two ports make the same-cycle double fault and the port 0 priority reachable. They also allow a clean access on one port to be cancelled by a fault on the other. Full 32-bit addresses let random stimulus cover every low-bit offset with every size code, loads and stores on both ports, and software writes that collide with faults.

// File: rtl/dalign_pkg.sv
// Package: shared size encoding and alignment rule for the alignment fault unit.
// Assumes size codes are fixed by the address generators: 00 byte, 01 half,
// 10 word; 11 is spare and is treated as a word.
package dalign_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_SPARE = 2'b11
    } acc_size_e;

    // Natural alignment rule on the two low address bits.
    function automatic logic is_misaligned(acc_size_e sz, logic [1:0] lo);
        logic mis;
        case (sz)
            SZ_BYTE: mis = 1'b0;
            SZ_HALF: mis = lo[0];
            default: mis = (lo != 2'b00);
        endcase
        return mis;
    endfunction

endpackage

// File: rtl/dalign_port_chk.sv
// Module: dalign_port_chk
// Checks one address-generator port for natural alignment.
// Assumes the address is a byte address. Only bits [1:0] matter for sizes up to a word.
module dalign_port_chk
    import dalign_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          vld,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output logic          fault
);

    // Flag a valid access whose low address bits break its size's alignment.
    always_comb begin
        fault = vld & is_misaligned(acc_size_e'(size), addr[1:0]);
    end

endmodule

// File: rtl/dalign_fault_select.sv
// Module: dalign_fault_select
// Merges per-port fault flags and picks the address to record.
// Assumes the lowest-numbered faulting port has priority.
module dalign_fault_select #(
    parameter int NP = 2,
    parameter int AW = 32
) (
    input  logic [NP-1:0]    port_fault,
    input  logic [NP*AW-1:0] port_addr,
    output logic             any_fault,
    output logic [AW-1:0]    sel_addr
);

    // Scan from the highest port down so the lowest faulting port wins last.
    always_comb begin
        any_fault = |port_fault;
        sel_addr  = '0;
        for (int p = NP - 1; p >= 0; p--) begin
            if (port_fault[p]) begin
                sel_addr = port_addr[p*AW +: AW];
            end
        end
    end

endmodule

// File: rtl/dalign_capture.sv
// Module: dalign_capture
// Holds the exception request, cause, fault address and return PC.
// Assumes a fault in the same cycle as a software write takes precedence.
// Synchronous active-low reset.
module dalign_capture #(
    parameter int          AW         = 32,
    parameter int          PCW        = 32,
    parameter int          CW         = 8,
    parameter logic [CW-1:0] CAUSE_CODE = 8'h24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           any_fault,
    input  logic [AW-1:0]  sel_addr,
    input  logic [PCW-1:0] instr_pc,
    input  logic           sw_fa_we,
    input  logic [AW-1:0]  sw_fa_data,
    output logic           exc_req,
    output logic [CW-1:0]  cause_q,
    output logic [AW-1:0]  fault_addr_q,
    output logic [PCW-1:0] ret_pc_q
);

    // Raise the exception request for the cycle after each faulting cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_req <= 1'b0;
        end else begin
            exc_req <= any_fault;
        end
    end

    // Load the cause code and return PC only when a fault is detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q  <= '0;
            ret_pc_q <= '0;
        end else if (any_fault) begin
            cause_q  <= CAUSE_CODE;
            ret_pc_q <= instr_pc;
        end
    end

    // Update the fault address from a fault first, else from software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_addr_q <= '0;
        end else if (any_fault) begin
            fault_addr_q <= sel_addr;
        end else if (sw_fa_we) begin
            fault_addr_q <= sw_fa_data;
        end
    end

endmodule

// File: rtl/dalign_fault_unit.sv
// Module: dalign_fault_unit (top)
// Checks every address-generator port for natural alignment. Any fault
// cancels all memory operations of the cycle and captures the fault state.
// Assumes all ports in one cycle belong to one instruction with PC instr_pc.
// Synchronous active-low reset.
module dalign_fault_unit #(
    parameter int            NP         = 2,
    parameter int            AW         = 32,
    parameter int            PCW        = 32,
    parameter int            CW         = 8,
    parameter logic [CW-1:0] CAUSE_CODE = 8'h24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP-1:0]    acc_vld,
    input  logic [NP*AW-1:0] acc_addr,
    input  logic [NP*2-1:0]  acc_size,
    input  logic [NP-1:0]    acc_wr,
    input  logic [PCW-1:0]   instr_pc,
    input  logic             sw_fa_we,
    input  logic [AW-1:0]    sw_fa_data,
    output logic [NP-1:0]    mem_req,
    output logic [NP-1:0]    mem_we,
    output logic [NP-1:0]    load_en,
    output logic             exc_req,
    output logic [CW-1:0]    cause_q,
    output logic [AW-1:0]    fault_addr_q,
    output logic [PCW-1:0]   ret_pc_q
);

    localparam int SZW = 2;

    logic [NP-1:0] port_fault;
    logic          any_fault;
    logic [AW-1:0] sel_addr;

    // One alignment checker per address-generator port.
    for (genvar p = 0; p < NP; p++) begin : g_port
        dalign_port_chk #(.AW(AW)) u_chk (
            .vld   (acc_vld[p]),
            .addr  (acc_addr[p*AW +: AW]),
            .size  (acc_size[p*SZW +: SZW]),
            .fault (port_fault[p])
        );
    end

    dalign_fault_select #(.NP(NP), .AW(AW)) u_sel (
        .port_fault (port_fault),
        .port_addr  (acc_addr),
        .any_fault  (any_fault),
        .sel_addr   (sel_addr)
    );

    dalign_capture #(
        .AW(AW), .PCW(PCW), .CW(CW), .CAUSE_CODE(CAUSE_CODE)
    ) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_fault    (any_fault),
        .sel_addr     (sel_addr),
        .instr_pc     (instr_pc),
        .sw_fa_we     (sw_fa_we),
        .sw_fa_data   (sw_fa_data),
        .exc_req      (exc_req),
        .cause_q      (cause_q),
        .fault_addr_q (fault_addr_q),
        .ret_pc_q     (ret_pc_q)
    );

    // Cancel every port's memory operation in a faulting cycle.
    always_comb begin
        mem_req = any_fault ? '0 : acc_vld;
        mem_we  = mem_req & acc_wr;
        load_en = mem_req & ~acc_wr;
    end

endmodule

// File: rtl/dalign_fault_unit_chk.sv
// Module: dalign_fault_unit_chk
// Property checker bound to dalign_fault_unit. It recomputes port faults
// from the port values on its own to relate inputs to outputs over time.
module dalign_fault_unit_chk #(
    parameter int            NP         = 2,
    parameter int            AW         = 32,
    parameter int            PCW        = 32,
    parameter int            CW         = 8,
    parameter logic [CW-1:0] CAUSE_CODE = 8'h24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NP-1:0]    acc_vld,
    input logic [NP*AW-1:0] acc_addr,
    input logic [NP*2-1:0]  acc_size,
    input logic [NP-1:0]    acc_wr,
    input logic [PCW-1:0]   instr_pc,
    input logic             sw_fa_we,
    input logic [AW-1:0]    sw_fa_data,
    input logic [NP-1:0]    mem_req,
    input logic [NP-1:0]    mem_we,
    input logic [NP-1:0]    load_en,
    input logic             exc_req,
    input logic [CW-1:0]    cause_q,
    input logic [AW-1:0]    fault_addr_q,
    input logic [PCW-1:0]   ret_pc_q
);

    logic f0;
    logic any_f;
    logic all_byte;

    // Independent view of the alignment rule from the ports.
    always_comb begin
        any_f    = 1'b0;
        all_byte = 1'b1;
        f0       = 1'b0;
        for (int p = 0; p < NP; p++) begin
            logic [1:0] sz;
            logic [1:0] lo;
            logic       f;
            sz = acc_size[p*2 +: 2];
            lo = acc_addr[p*AW +: 2];
            f  = acc_vld[p] && ((sz == 2'b01 && lo[0]) || (sz[1] && lo != 2'b00));
            if (p == 0) f0 = f;
            any_f = any_f | f;
            if (acc_vld[p] && sz != 2'b00) all_byte = 1'b0;
        end
    end

    // R5: a faulting cycle drives no write strobe and no load update.
    a_r5_no_strobe_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        any_f |-> (mem_we == '0 && load_en == '0 && mem_req == '0));

    // R6: the request follows a faulting cycle and only a faulting cycle.
    a_r6_exc_follows_fault: assert property (@(posedge clk) disable iff (!rst_n)
        any_f |=> exc_req);
    a_r6_no_spurious_exc: assert property (@(posedge clk) disable iff (!rst_n)
        !any_f |=> !exc_req);

    // R7: the cause register shows the alignment code with the request.
    a_r7_cause_code: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> cause_q == CAUSE_CODE);

    // R8: port 0's exact address is recorded when it faults.
    a_r8_port0_addr: assert property (@(posedge clk) disable iff (!rst_n)
        f0 |=> fault_addr_q == $past(acc_addr[AW-1:0]));

    // R9: the return PC is the PC of the faulting cycle.
    a_r9_ret_pc: assert property (@(posedge clk) disable iff (!rst_n)
        any_f |=> ret_pc_q == $past(instr_pc));

    // R10: without fault or software write the fault address holds.
    a_r10_fa_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_f && !sw_fa_we) |=> $stable(fault_addr_q));

    // R3: byte-only traffic never requests an exception.
    a_r3_byte_no_exc: assert property (@(posedge clk) disable iff (!rst_n)
        all_byte |=> !exc_req);

endmodule

bind dalign_fault_unit dalign_fault_unit_chk #(
    .NP(NP), .AW(AW), .PCW(PCW), .CW(CW), .CAUSE_CODE(CAUSE_CODE)
) u_chk (.*);

// File: tb/dalign_fault_unit_tb.sv
`timescale 1ns/1ps
module dalign_fault_unit_tb;

    localparam int NP  = 2;
    localparam int AW  = 32;
    localparam int PCW = 32;
    localparam int CW  = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NP-1:0]    acc_vld;
    logic [NP*AW-1:0] acc_addr;
    logic [NP*2-1:0]  acc_size;
    logic [NP-1:0]    acc_wr;
    logic [PCW-1:0]   instr_pc;
    logic             sw_fa_we;
    logic [AW-1:0]    sw_fa_data;
    logic [NP-1:0]    mem_req, mem_we, load_en;
    logic             exc_req;
    logic [CW-1:0]    cause_q;
    logic [AW-1:0]    fault_addr_q;
    logic [PCW-1:0]   ret_pc_q;

    int n_chk  = 0;
    int n_fail = 0;

    // Model state: what the capture registers should hold.
    logic           m_exc;
    logic [CW-1:0]  m_cause;
    logic [AW-1:0]  m_fa;
    logic [PCW-1:0] m_pc;
    string          tag_comb = "R5";
    string          tag_fa   = "R8";

    always #2.5 clk = ~clk;

    dalign_fault_unit u_dut (.*);

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Alignment rule from R1-R3.
    function automatic logic exp_mis(logic [1:0] sz, logic [1:0] lo);
        if (sz == 2'b00) return 1'b0;
        if (sz == 2'b01) return lo[0];
        return lo != 2'b00;
    endfunction

    // One cycle: check registers, drive, check combinational outputs, advance model.
    task automatic apply(logic [1:0] v, logic [AW-1:0] a0, logic [AW-1:0] a1,
                         logic [1:0] s0, logic [1:0] s1, logic [1:0] w,
                         logic [PCW-1:0] pc, logic swe, logic [AW-1:0] swd);
        logic f0, f1, anyf;
        logic [1:0] er;
        @(negedge clk);
        check("R6", {63'd0, exc_req}, {63'd0, m_exc});
        check("R7", {56'd0, cause_q}, {56'd0, m_cause});
        check(tag_fa, {32'd0, fault_addr_q}, {32'd0, m_fa});
        check("R9", {32'd0, ret_pc_q}, {32'd0, m_pc});
        acc_vld    = v;
        acc_addr   = {a1, a0};
        acc_size   = {s1, s0};
        acc_wr     = w;
        instr_pc   = pc;
        sw_fa_we   = swe;
        sw_fa_data = swd;
        #1;
        f0   = v[0] & exp_mis(s0, a0[1:0]);
        f1   = v[1] & exp_mis(s1, a1[1:0]);
        anyf = f0 | f1;
        er   = anyf ? 2'b00 : v;
        check(tag_comb, {58'd0, mem_req, mem_we, load_en},
              {58'd0, er, er & w, er & ~w});
        m_exc = anyf;
        if (anyf) begin
            m_cause = 8'h24;
            m_pc    = pc;
            m_fa    = f0 ? a0 : a1;
        end else if (swe) begin
            m_fa = swd;
        end
    endtask

    task automatic idle();
        apply(2'b00, '0, '0, 2'b00, 2'b00, 2'b00, '0, 1'b0, '0);
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; acc_vld = '0; acc_addr = '0; acc_size = '0; acc_wr = '0;
        instr_pc = '0; sw_fa_we = 1'b0; sw_fa_data = '0;
        m_exc = 1'b0; m_cause = '0; m_fa = '0; m_pc = '0;
        repeat (3) @(posedge clk);
        // R11: reset state, driven with a faulting pattern present during reset
        acc_vld = 2'b11; acc_addr = {32'h3, 32'h1}; acc_size = 4'b1010;
        @(posedge clk);
        @(negedge clk);
        check("R11", {63'd0, exc_req}, 64'd0);
        check("R11", {56'd0, cause_q}, 64'd0);
        check("R11", {32'd0, fault_addr_q}, 64'd0);
        check("R11", {32'd0, ret_pc_q}, 64'd0);
        acc_vld = '0;
        rst_n = 1'b1;

        // R10: software presets the fault address, then it holds
        tag_fa = "R10";
        apply(2'b00, '0, '0, 2'b00, 2'b00, 2'b00, '0, 1'b1, 32'hCAFE_0000);
        apply(2'b11, 32'h2000, 32'h2004, 2'b10, 2'b10, 2'b01, 32'h40, 1'b0, '0);
        apply(2'b00, '0, '0, 2'b00, 2'b00, 2'b00, '0, 1'b1, 32'h0);
        idle();
        idle();
        tag_fa = "R8";

        // R1: odd halfword on port 0 (store), then on port 1 (load)
        tag_comb = "R1";
        apply(2'b01, 32'h1001, '0, 2'b01, 2'b00, 2'b01, 32'h100, 1'b0, '0);
        idle();
        apply(2'b10, '0, 32'h1001, 2'b00, 2'b01, 2'b00, 32'h104, 1'b0, '0);
        idle();
        apply(2'b01, 32'h1002, '0, 2'b01, 2'b00, 2'b00, 32'h108, 1'b0, '0);
        idle();

        // R2: word offsets 1,2,3 on both ports, loads and stores; spare code
        tag_comb = "R2";
        for (int off = 1; off < 4; off++) begin
            for (int wr = 0; wr < 2; wr++) begin
                apply(2'b01, 32'h1000 + off, '0, 2'b10, 2'b00, 2'(wr), 32'h200 + off, 1'b0, '0);
                idle();
                apply(2'b10, '0, 32'h1000 + off, 2'b00, 2'b10, 2'(wr << 1), 32'h300 + off, 1'b0, '0);
                idle();
            end
        end
        apply(2'b01, 32'h1002, '0, 2'b11, 2'b00, 2'b00, 32'h3F0, 1'b0, '0);
        idle();

        // R3: bytes at every offset never fault
        tag_comb = "R3";
        for (int off = 0; off < 4; off++) begin
            apply(2'b11, 32'h5000 + off, 32'h6003 - off, 2'b00, 2'b00, 2'b10, 32'h400, 1'b0, '0);
        end
        idle();

        // R4: aligned port 0 cancelled by a misaligned port 1
        tag_comb = "R4";
        apply(2'b11, 32'h7000, 32'h7002, 2'b10, 2'b10, 2'b01, 32'h500, 1'b0, '0);
        idle();

        // R8: both ports fault together; port 0 address wins
        tag_comb = "R8";
        apply(2'b11, 32'h8003, 32'h9001, 2'b10, 2'b01, 2'b11, 32'h600, 1'b0, '0);
        idle();

        // R10: fault beats a same-cycle software write
        tag_comb = "R10"; tag_fa = "R10";
        apply(2'b01, 32'hA001, '0, 2'b01, 2'b00, 2'b00, 32'h700, 1'b1, 32'h1234_5678);
        idle();
        tag_fa = "R8";

        // Constrained random traffic, checked against the same rules
        tag_comb = "R5";
        for (int i = 0; i < 4000; i++) begin
            apply(2'($urandom), $urandom, $urandom, 2'($urandom), 2'($urandom),
                  2'($urandom), $urandom, ($urandom % 8) == 0, $urandom);
        end
        idle();
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule